// File: doc/BRIEF.md
# IO Boundary Tile with Valid-Window Generator

This cell sits where the array fabric meets the global buffer. A 16-bit word and a 1-bit signal pass combinationally in each direction. The cell adds no register and no cycle of delay on these paths, so it can sit on the data path at no cost in latency.

A small configuration port sets the cell's mode and a cycle limit, and both values can be read back. In pass mode the 1-bit lane toward the global buffer simply follows the fabric. In valid mode that lane is driven by an internal window generator instead. A start pulse on the global-side 1-bit input opens a window, the output is then high for exactly the configured number of cycles, and afterwards it stays low. The 16-bit lanes keep passing data through throughout.

A stall input freezes the window generator while the configuration is being loaded or the array is paused. A new start pulse during an open window begins the count again from zero.

Top module: `io_valid_tile`

## Requirements
- R1: `glb_out16` equals `fab_in16` and `fab_out16` equals `glb_in16` in the same cycle, in every mode and state.
- R2: `fab_out1` always equals `glb_in1`. When the mode bit is 0, `glb_out1` equals `fab_in1` in the same cycle.
- R3: When `cfg_we` is high at a clock edge, a write to address 0 loads the mode bit from `cfg_wdata[0]`, and a write to address 1 loads the cycle limit from `cfg_wdata[15:0]`. Writes to any other address change nothing.
- R4: `cfg_rdata` is combinational. Address 0 returns the mode bit zero-extended, address 1 returns the cycle limit zero-extended, and every other address returns 0.
- R5: When the mode bit is 1, `glb_out1` is 0 while no window is open, whatever the value of `fab_in1`.
- R6: When the mode bit is 1, an unstalled clock edge with `glb_in1` high opens a window. `glb_out1` is then 1 for exactly N unstalled cycles after the last such edge, where N is the cycle limit, and then returns to 0. A limit of 0 opens no window.
- R7: While `stall` is high, the window state holds at each edge, so `glb_out1` does not advance.
- R8: A start pulse that arrives while a window is open restarts the count from zero, giving a full N cycles from that edge.
- R9: A clock edge with `rst` high clears the mode bit, the cycle limit and the window. After such an edge `glb_out1` follows `fab_in1` and both registers read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Freezes the window generator |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register address (write and read) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Readback of the addressed register |
| fab_in16 | input | 16 | Word from the fabric |
| fab_in1 | input | 1 | Bit from the fabric |
| glb_in16 | input | 16 | Word from the global buffer |
| glb_in1 | input | 1 | Bit from the global buffer; start pulse in valid mode |
| glb_out16 | output | 16 | Word to the global buffer |
| glb_out1 | output | 1 | Bit to the global buffer (passthrough or valid window) |
| fab_out16 | output | 16 | Word to the fabric |
| fab_out1 | output | 1 | Bit to the fabric |

## Verification
The passthrough lanes and `cfg_rdata` are due in the same cycle as their inputs. The bench therefore drives them and compares a moment later, with no clock edge in between. Register writes, start pulses and stalls take effect at the next rising edge. For these the bench updates its reference model just before each edge and compares `glb_out1` one time step after the edge. Window length is counted in edges from the start edge, so a 16-cycle window is checked as 16 highs followed by lows.

// File: rtl/io_tile_pkg.sv
package io_tile_pkg;
    localparam int CFG_ADDR_MODE = 0;
    localparam int CFG_ADDR_MAXC = 1;

    typedef enum logic {
        MODE_PASS  = 1'b0,
        MODE_VALID = 1'b1
    } io_mode_e;
endpackage

// File: rtl/io_cfg_regs.sv
module io_cfg_regs
    import io_tile_pkg::*;
#(
    parameter int CFG_AW = 8,
    parameter int CFG_DW = 32,
    parameter int MAXC_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CFG_AW-1:0] addr,
    input  logic [CFG_DW-1:0] wdata,
    output logic              mode_o,
    output logic [MAXC_W-1:0] maxc_o,
    output logic [CFG_DW-1:0] rdata_o
);
    typedef struct packed {
        logic              mode;
        logic [MAXC_W-1:0] maxc;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[CFG_DW-1:MAXC_W];

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (addr == CFG_AW'(CFG_ADDR_MODE)) cfg_d.mode = wdata[0];
            if (addr == CFG_AW'(CFG_ADDR_MAXC)) cfg_d.maxc = wdata[MAXC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_d;
    end

    always_comb begin
        rdata_o = '0;
        if (addr == CFG_AW'(CFG_ADDR_MODE)) rdata_o = CFG_DW'(cfg_q.mode);
        if (addr == CFG_AW'(CFG_ADDR_MAXC)) rdata_o = CFG_DW'(cfg_q.maxc);
    end

    assign mode_o = cfg_q.mode;
    assign maxc_o = cfg_q.maxc;
endmodule

// File: rtl/io_valid_win.sv
module io_valid_win #(
    parameter int MAXC_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall,
    input  logic              mode,
    input  logic [MAXC_W-1:0] maxc,
    input  logic              start,
    output logic              act_o,
    output logic [MAXC_W-1:0] cnt_o
);
    localparam int CW = MAXC_W + 1;

    typedef struct packed {
        logic              act;
        logic [MAXC_W-1:0] cnt;
    } win_t;

    win_t win_d, win_q;
    logic [CW-1:0] next_cnt;

    assign next_cnt = {1'b0, win_q.cnt} + CW'(1);

    always_comb begin
        win_d = win_q;
        if (!stall) begin
            if (!mode) begin
                win_d = '0;
            end else if (start) begin
                win_d.act = |maxc;
                win_d.cnt = '0;
            end else if (win_q.act) begin
                if (next_cnt >= {1'b0, maxc}) begin
                    win_d.act = 1'b0;
                    win_d.cnt = '0;
                end else begin
                    win_d.cnt = next_cnt[MAXC_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) win_q <= '0;
        else     win_q <= win_d;
    end

    assign act_o = win_q.act;
    assign cnt_o = win_q.cnt;
endmodule

// File: rtl/io_lane_mux.sv
module io_lane_mux #(
    parameter int DATA_W = 16
) (
    input  logic              mode,
    input  logic              win_act,
    input  logic [DATA_W-1:0] fab_in_w,
    input  logic              fab_in_b,
    input  logic [DATA_W-1:0] glb_in_w,
    input  logic              glb_in_b,
    output logic [DATA_W-1:0] glb_out_w,
    output logic              glb_out_b,
    output logic [DATA_W-1:0] fab_out_w,
    output logic              fab_out_b
);
    always_comb begin
        glb_out_w = fab_in_w;
        fab_out_w = glb_in_w;
        fab_out_b = glb_in_b;
        glb_out_b = mode ? win_act : fab_in_b;
    end
endmodule

// File: rtl/io_valid_tile.sv
module io_valid_tile #(
    parameter int DATA_W = 16,
    parameter int CFG_AW = 8,
    parameter int CFG_DW = 32,
    parameter int MAXC_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic [CFG_DW-1:0] cfg_rdata,
    input  logic [DATA_W-1:0] fab_in16,
    input  logic              fab_in1,
    input  logic [DATA_W-1:0] glb_in16,
    input  logic              glb_in1,
    output logic [DATA_W-1:0] glb_out16,
    output logic              glb_out1,
    output logic [DATA_W-1:0] fab_out16,
    output logic              fab_out1
);
    logic              mode_q;
    logic [MAXC_W-1:0] maxc_q;
    logic              win_act;
    logic [MAXC_W-1:0] win_cnt;

    io_cfg_regs #(.CFG_AW(CFG_AW), .CFG_DW(CFG_DW), .MAXC_W(MAXC_W)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .mode_o (mode_q),
        .maxc_o (maxc_q),
        .rdata_o(cfg_rdata)
    );

    io_valid_win #(.MAXC_W(MAXC_W)) u_win (
        .clk  (clk),
        .rst  (rst),
        .stall(stall),
        .mode (mode_q),
        .maxc (maxc_q),
        .start(glb_in1),
        .act_o(win_act),
        .cnt_o(win_cnt)
    );

    io_lane_mux #(.DATA_W(DATA_W)) u_mux (
        .mode     (mode_q),
        .win_act  (win_act),
        .fab_in_w (fab_in16),
        .fab_in_b (fab_in1),
        .glb_in_w (glb_in16),
        .glb_in_b (glb_in1),
        .glb_out_w(glb_out16),
        .glb_out_b(glb_out1),
        .fab_out_w(fab_out16),
        .fab_out_b(fab_out1)
    );
endmodule

// File: rtl/io_valid_tile_chk.sv
module io_valid_tile_chk #(
    parameter int DATA_W = 16,
    parameter int CFG_AW = 8,
    parameter int MAXC_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              stall,
    input logic              cfg_we,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [MAXC_W-1:0] wdata_lo,
    input logic              mode_q,
    input logic [MAXC_W-1:0] maxc_q,
    input logic              win_act,
    input logic [MAXC_W-1:0] win_cnt,
    input logic [DATA_W-1:0] fab_in16,
    input logic [DATA_W-1:0] glb_in16,
    input logic [DATA_W-1:0] glb_out16,
    input logic [DATA_W-1:0] fab_out16,
    input logic              fab_in1,
    input logic              glb_in1,
    input logic              glb_out1,
    input logic              fab_out1
);
    localparam int CW = MAXC_W + 1;

    AST_FWD_WORDS: assert property (@(posedge clk) disable iff (rst)
        (glb_out16 == fab_in16) && (fab_out16 == glb_in16)); // R1
    AST_PASS_BITS: assert property (@(posedge clk) disable iff (rst)
        (fab_out1 == glb_in1) && (!mode_q -> (glb_out1 == fab_in1))); // R2
    AST_LIMIT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == CFG_AW'(1)) |=> (maxc_q == $past(wdata_lo))); // R3
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        (mode_q && !win_act) |-> !glb_out1); // R5
    AST_START_OPENS: assert property (@(posedge clk) disable iff (rst)
        (!stall && mode_q && glb_in1 && maxc_q != '0) |=> win_act); // R6
    AST_WIN_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (!stall && mode_q && !glb_in1 && win_act &&
         ({1'b0, win_cnt} + CW'(1) >= {1'b0, maxc_q})) |=> !win_act); // R6
    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(win_act) && $stable(win_cnt))); // R7
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!stall && mode_q && glb_in1) |=> (win_cnt == '0)); // R8
    AST_RST_CLEARS: assert property (@(posedge clk)
        rst |=> (!win_act && !mode_q && maxc_q == '0)); // R9
endmodule

bind io_valid_tile io_valid_tile_chk #(
    .DATA_W(DATA_W), .CFG_AW(CFG_AW), .MAXC_W(MAXC_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .stall    (stall),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .wdata_lo (cfg_wdata[MAXC_W-1:0]),
    .mode_q   (mode_q),
    .maxc_q   (maxc_q),
    .win_act  (win_act),
    .win_cnt  (win_cnt),
    .fab_in16 (fab_in16),
    .glb_in16 (glb_in16),
    .glb_out16(glb_out16),
    .fab_out16(fab_out16),
    .fab_in1  (fab_in1),
    .glb_in1  (glb_in1),
    .glb_out1 (glb_out1),
    .fab_out1 (fab_out1)
);

// File: tb/sim_io_valid_tile.sv
`timescale 1ns/1ps
module sim_io_valid_tile;
    logic        clk = 1'b0;
    logic        rst, stall, cfg_we;
    logic [7:0]  cfg_addr;
    logic [31:0] cfg_wdata, cfg_rdata;
    logic [15:0] fab_in16, glb_in16, glb_out16, fab_out16;
    logic        fab_in1, glb_in1, glb_out1, fab_out1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model state
    bit      m_mode, m_act;
    int      m_max, m_cnt;

    always #4 clk = ~clk;

    io_valid_tile u0 (
        .clk(clk), .rst(rst), .stall(stall), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .fab_in16(fab_in16), .fab_in1(fab_in1), .glb_in16(glb_in16),
        .glb_in1(glb_in1), .glb_out16(glb_out16), .glb_out1(glb_out1),
        .fab_out16(fab_out16), .fab_out1(fab_out1)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_out1();
        return m_mode ? m_act : fab_in1;
    endfunction

    // advance the model by one edge using the values now on the inputs
    task automatic model_edge();
        if (rst) begin
            m_mode = 0; m_max = 0; m_act = 0; m_cnt = 0;
        end else begin
            if (!stall) begin
                if (!m_mode) begin
                    m_act = 0; m_cnt = 0;
                end else if (glb_in1) begin
                    m_act = (m_max != 0); m_cnt = 0;
                end else if (m_act) begin
                    if (m_cnt + 1 >= m_max) begin m_act = 0; m_cnt = 0; end
                    else m_cnt = m_cnt + 1;
                end
            end
            if (cfg_we && cfg_addr == 8'd0) m_mode = cfg_wdata[0];
            if (cfg_we && cfg_addr == 8'd1) m_max = int'(cfg_wdata[15:0]);
        end
    endtask

    task automatic tick();
        model_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic cfg_write(logic [7:0] a, logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic cfg_read(string req, logic [7:0] a, logic [31:0] exp);
        cfg_addr = a;
        #1;
        chk(req, cfg_rdata, exp);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        rst = 1; stall = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        fab_in16 = 0; glb_in16 = 0; fab_in1 = 0; glb_in1 = 0;
        m_mode = 0; m_max = 0; m_act = 0; m_cnt = 0;
        #1;
        tick(); tick();
        rst = 0;
        // reset state
        fab_in1 = 1; #1;
        chk("R9 reset: out1 follows fabric", glb_out1, 1);
        cfg_read("R9 reset mode", 8'd0, 0);
        cfg_read("R9 reset limit", 8'd1, 0);

        // R1/R2 random passthrough in pass mode
        for (int i = 0; i < 40; i++) begin
            fab_in16 = 16'($urandom); glb_in16 = 16'($urandom);
            fab_in1 = 1'($urandom); glb_in1 = 1'($urandom);
            #1;
            chk("R1 fab->glb word", glb_out16, fab_in16);
            chk("R1 glb->fab word", fab_out16, glb_in16);
            chk("R2 fab->glb bit", glb_out1, fab_in1);
            chk("R2 glb->fab bit", fab_out1, glb_in1);
            if (i % 8 == 0) tick();
        end
        glb_in1 = 0;

        // R3/R4 configuration under stall, readback
        stall = 1;
        cfg_write(8'd0, 32'hFFFF_FFF1);
        cfg_write(8'd1, 32'hABCD_0010);
        cfg_read("R3 mode load", 8'd0, 32'd1);
        cfg_read("R3 limit load", 8'd1, 32'd16);
        cfg_write(8'd5, 32'hFFFF_FFFF);
        cfg_read("R3 stray write ignored mode", 8'd0, 32'd1);
        cfg_read("R3 stray write ignored limit", 8'd1, 32'd16);
        cfg_read("R4 unmapped reads zero", 8'd5, 32'd0);
        stall = 0;

        // R5 fabric bit has no effect while idle in valid mode
        for (int i = 0; i < 10; i++) begin
            fab_in16 = 16'($urandom); fab_in1 = 1'($urandom);
            tick();
            chk("R5 idle low", glb_out1, 0);
            chk("R1 word during valid mode", glb_out16, fab_in16);
        end

        // R6 window of exactly 16
        glb_in1 = 1; tick(); glb_in1 = 0;
        for (int i = 0; i < 16; i++) begin chk("R6 window high", glb_out1, 1); tick(); end
        for (int i = 0; i < 16; i++) begin chk("R6 after window low", glb_out1, 0); tick(); end

        // R6 zero limit opens nothing
        cfg_write(8'd1, 32'd0);
        glb_in1 = 1; tick(); glb_in1 = 0;
        chk("R6 zero limit", glb_out1, 0);
        tick();
        chk("R6 zero limit later", glb_out1, 0);

        // R8 restart mid-window
        cfg_write(8'd1, 32'd5);
        glb_in1 = 1; tick(); glb_in1 = 0;
        tick(); tick(); tick();
        glb_in1 = 1; tick(); glb_in1 = 0;
        for (int i = 0; i < 5; i++) begin chk("R8 restarted window high", glb_out1, 1); tick(); end
        chk("R8 restarted window ends", glb_out1, 0);

        // R7 stall holds the window
        cfg_write(8'd1, 32'd6);
        glb_in1 = 1; tick(); glb_in1 = 0;
        tick(); tick();
        stall = 1;
        for (int i = 0; i < 4; i++) begin tick(); chk("R7 stalled window holds", glb_out1, 1); end
        stall = 0;
        for (int i = 0; i < 4; i++) begin chk("R7 resumed window high", glb_out1, 1); tick(); end
        chk("R7 resumed window ends", glb_out1, 0);

        // R9 reset during a window
        glb_in1 = 1; tick(); glb_in1 = 0;
        rst = 1; tick(); rst = 0;
        fab_in1 = 0; #1;
        chk("R9 window cleared", glb_out1, 0);
        fab_in1 = 1; #1;
        chk("R9 pass mode after reset", glb_out1, 1);
        cfg_read("R9 limit cleared", 8'd1, 0);

        // random mixed phase against the model
        cfg_write(8'd0, 32'd1);
        cfg_write(8'd1, 32'd7);
        for (int i = 0; i < 400; i++) begin
            glb_in1 = ($urandom % 12) == 0;
            stall = ($urandom % 5) == 0;
            fab_in1 = 1'($urandom);
            fab_in16 = 16'($urandom);
            cfg_we = ($urandom % 40) == 0;
            cfg_addr = 8'($urandom % 3);
            cfg_wdata = (cfg_addr == 8'd0) ? 32'(($urandom % 4) != 0) : 32'($urandom % 12);
            tick();
            cfg_we = 0;
            chk("R6 R7 R8 random window", glb_out1, exp_out1());
            chk("R1 random word", glb_out16, fab_in16);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule